// File: doc/BRIEF.md
# Receive-Enable Delay Digit Normalizer

This block keeps one receive-enable delay setting for a memory read path. The setting is stored as four nested digits: a coarse cycle count, a phase, a tap and a fine step. A calibration sequencer outside the block decides which adjustment to make next. It then sends the block a single step command. The block applies that step to the digits. It then carries or borrows between neighbouring digits, one adjustment per clock, until every digit is back in its legal range. After that it shows the result as plain digits and as packed register words.

The radices are uneven and depend on the speed grade. The fine digit wraps into the tap digit. A tap overflow moves the phase by two units. The phase wraps into the coarse count. A quarter-cycle step adds half the tap radix to the tap digit. When the tap radix is odd, the missing half tap is made up with half a tap's worth of fine steps. The block keeps a sticky error when normalization leaves the coarse count outside its 4-bit range.

The control is a two-state machine. In `S_IDLE` the digits are settled and commands are accepted. In `S_NORM` the block performs one carry or borrow per cycle. These transitions are used:
- **accept**: `S_IDLE` to `S_NORM`, on a step command while no error is held.
- **load**: any state to `S_NORM`, on a load strobe.
- **settle**: `S_NORM` to `S_IDLE`, once the fine, tap and phase digits are all in range. On this transition the coarse range check updates the error flag.
- **hold**: any other cycle, where the state stays as it is.

Top module: `rx_delay_normalizer`

## Requirements
- R1: After reset, all four digits and the preamble offset are 0, `done` is 1, `err` is 0, and both packed words are 0.
- R2: A `load` pulse writes `ld_coarse`, `ld_phase`, `ld_tap`, `ld_fine` and `ld_pre` into the block, clears `err`, and starts normalization. If `load` and `op_valid` are both high in the same cycle, `load` wins and the op is dropped.
- R3: When `fast_grade`=1, the tap radix is 9 and the fine radix is 8. When `fast_grade`=0, the tap radix is 12 and the fine radix is 1. The grade is sampled on the cycle a load or command is accepted, and that sampled grade is used for the whole normalization.
- R4: Op codes:
  - 0: quarter step. Tap increases by tap_radix>>1. If the tap radix is odd, fine also increases by fine_radix>>1.
  - 1: quarter backstep. The same amounts are subtracted.
  - 2: coarse minus 1.
  - 3: phase minus 2.
  - 4: fine plus 1.
  - 5 to 7: the digits are left unchanged, and the command only re-runs normalization.
- R5: Normalization keeps fine in 0..fine_radix-1. An overflow subtracts the radix from fine and adds 1 to tap. An underflow adds the radix to fine and subtracts 1 from tap.
- R6: Normalization keeps tap in 0..tap_radix-1. Each overflow adds 2 to the phase. Each underflow subtracts 2 from the phase.
- R7: Normalization keeps phase in 0..3. Each overflow adds 1 to coarse. Each underflow subtracts 1 from coarse.
- R8: Exactly one carry or borrow is performed per clock. The order of priority is fine, then tap, then phase. Let n be the number of adjustments needed. `done` is low in the cycle after the accepting edge, and is high again after n+1 edges. The weighted value of the setting is the same before and after every adjustment.
- R9: If coarse is outside 0..15 once the other digits settle, `err` is raised and `done` stays low. While `err` is held, step commands are ignored and the digits stay fixed. Only a load clears `err`.
- R10: A command that arrives while normalization is running (`done` low) is ignored.
- R11: Packed words:
  - `grp_word` holds tap in [31:28], fine in [26:24], phase in [23:22] and the preamble offset in [21:20]. All other bits are 0.
  - `chan_word` holds the low four bits of coarse in [10:7]. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_grade | input | 1 | Speed-grade select, sampled on load or accept |
| load | input | 1 | Load strobe for the initial digits |
| ld_coarse | input | 4 | Initial coarse count |
| ld_phase | input | 2 | Initial phase |
| ld_tap | input | 4 | Initial tap |
| ld_fine | input | 3 | Initial fine step |
| ld_pre | input | 2 | Preamble offset, held and packed |
| op_valid | input | 1 | Step command strobe |
| op | input | 3 | Step op code |
| coarse_out | output | 4 | Coarse count (low bits) |
| phase_out | output | 2 | Phase digit |
| tap_out | output | 4 | Tap digit |
| fine_out | output | 3 | Fine digit |
| grp_word | output | 32 | Packed per-group register word |
| chan_word | output | 32 | Packed per-channel register word |
| done | output | 1 | Digits settled and coarse in range |
| err | output | 1 | Sticky coarse range error |

## Verification
Three functions can land on the same clock edge: a load, a step command, and a change of speed grade.

- **Load and command together.** The bench raises `load` and `op_valid` together. It then checks that the result matches the load alone.
- **Command during normalization.** The bench pulses a command one cycle after an accepting edge, while normalization is still running. It checks that the final digits ignore that command.
- **Grade change during normalization.** The bench flips `fast_grade` during a long normalization. It checks that the radices sampled at the accepting edge are still the ones in use.
- **Error state.** Once `err` is held, a further command must leave every output unchanged.

A sweep over start digits, every op code and both grades compares digits, words, error and latency against arithmetic in the bench.

// File: rtl/rxn_pkg.sv
package rxn_pkg;

    localparam int TAP_W    = 4;
    localparam int FINE_W   = 3;
    localparam int PH_W     = 2;
    localparam int PRE_W    = 2;
    localparam int OP_W     = 3;
    localparam int WORD_W   = 32;

    localparam int GRP_TAP_LSB   = 28;
    localparam int GRP_FINE_LSB  = 24;
    localparam int GRP_PH_LSB    = 22;
    localparam int GRP_PRE_LSB   = 20;
    localparam int CH_COARSE_LSB = 7;

    typedef enum logic [OP_W-1:0] {
        OP_QSTEP    = 3'd0,
        OP_QBACK    = 3'd1,
        OP_FULLBACK = 3'd2,
        OP_HALFBACK = 3'd3,
        OP_FINE     = 3'd4,
        OP_RSV5     = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } rxn_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_NORM = 1'b1
    } rxn_state_e;

endpackage

// File: rtl/rxn_step_apply.sv
module rxn_step_apply
    import rxn_pkg::*;
#(
    parameter int DIG_W    = 8,
    parameter int PH_STEP  = 2
) (
    input  rxn_op_e                  op_i,
    input  logic signed [DIG_W-1:0]  tb_i,
    input  logic signed [DIG_W-1:0]  pb_i,
    input  logic signed [DIG_W-1:0]  coarse_i,
    input  logic signed [DIG_W-1:0]  phase_i,
    input  logic signed [DIG_W-1:0]  tap_i,
    input  logic signed [DIG_W-1:0]  fine_i,
    output logic signed [DIG_W-1:0]  coarse_o,
    output logic signed [DIG_W-1:0]  phase_o,
    output logic signed [DIG_W-1:0]  tap_o,
    output logic signed [DIG_W-1:0]  fine_o
);

    localparam logic signed [DIG_W-1:0] ONE_S  = DIG_W'(1);
    localparam logic signed [DIG_W-1:0] PSTEP  = DIG_W'(PH_STEP);

    logic signed [DIG_W-1:0] q_tap;
    logic signed [DIG_W-1:0] q_fine;

    always_comb begin
        q_tap  = tb_i >>> 1;
        q_fine = tb_i[0] ? (pb_i >>> 1) : '0;
    end

    always_comb begin
        coarse_o = coarse_i;
        phase_o  = phase_i;
        tap_o    = tap_i;
        fine_o   = fine_i;
        case (op_i)
            OP_QSTEP: begin
                tap_o  = tap_i + q_tap;
                fine_o = fine_i + q_fine;
            end
            OP_QBACK: begin
                tap_o  = tap_i - q_tap;
                fine_o = fine_i - q_fine;
            end
            OP_FULLBACK: coarse_o = coarse_i - ONE_S;
            OP_HALFBACK: phase_o  = phase_i - PSTEP;
            OP_FINE:     fine_o   = fine_i + ONE_S;
            default: ;
        endcase
    end

endmodule

// File: rtl/rxn_carry_unit.sv
module rxn_carry_unit #(
    parameter int DIG_W    = 8,
    parameter int PH_STEP  = 2,
    parameter int PH_BOUND = 4
) (
    input  logic signed [DIG_W-1:0]  tb_i,
    input  logic signed [DIG_W-1:0]  pb_i,
    input  logic signed [DIG_W-1:0]  coarse_i,
    input  logic signed [DIG_W-1:0]  phase_i,
    input  logic signed [DIG_W-1:0]  tap_i,
    input  logic signed [DIG_W-1:0]  fine_i,
    output logic signed [DIG_W-1:0]  coarse_o,
    output logic signed [DIG_W-1:0]  phase_o,
    output logic signed [DIG_W-1:0]  tap_o,
    output logic signed [DIG_W-1:0]  fine_o,
    output logic                     settled_o
);

    localparam logic signed [DIG_W-1:0] ONE_S = DIG_W'(1);
    localparam logic signed [DIG_W-1:0] PSTEP = DIG_W'(PH_STEP);
    localparam logic signed [DIG_W-1:0] PLIM  = DIG_W'(PH_BOUND);

    always_comb begin
        coarse_o  = coarse_i;
        phase_o   = phase_i;
        tap_o     = tap_i;
        fine_o    = fine_i;
        settled_o = 1'b0;
        if (fine_i >= pb_i) begin
            fine_o = fine_i - pb_i;
            tap_o  = tap_i + ONE_S;
        end else if (fine_i < 0) begin
            fine_o = fine_i + pb_i;
            tap_o  = tap_i - ONE_S;
        end else if (tap_i >= tb_i) begin
            tap_o   = tap_i - tb_i;
            phase_o = phase_i + PSTEP;
        end else if (tap_i < 0) begin
            tap_o   = tap_i + tb_i;
            phase_o = phase_i - PSTEP;
        end else if (phase_i >= PLIM) begin
            phase_o  = phase_i - PLIM;
            coarse_o = coarse_i + ONE_S;
        end else if (phase_i < 0) begin
            phase_o  = phase_i + PLIM;
            coarse_o = coarse_i - ONE_S;
        end else begin
            settled_o = 1'b1;
        end
    end

endmodule

// File: rtl/rxn_pack.sv
module rxn_pack
    import rxn_pkg::*;
#(
    parameter int COARSE_W = 4
) (
    input  logic [TAP_W-1:0]    tap_i,
    input  logic [FINE_W-1:0]   fine_i,
    input  logic [PH_W-1:0]     phase_i,
    input  logic [PRE_W-1:0]    pre_i,
    input  logic [COARSE_W-1:0] coarse_i,
    output logic [WORD_W-1:0]   grp_word_o,
    output logic [WORD_W-1:0]   chan_word_o
);

    always_comb begin
        grp_word_o = '0;
        grp_word_o[GRP_TAP_LSB  +: TAP_W]  = tap_i;
        grp_word_o[GRP_FINE_LSB +: FINE_W] = fine_i;
        grp_word_o[GRP_PH_LSB   +: PH_W]   = phase_i;
        grp_word_o[GRP_PRE_LSB  +: PRE_W]  = pre_i;
        chan_word_o = '0;
        chan_word_o[CH_COARSE_LSB +: COARSE_W] = coarse_i;
    end

endmodule

// File: rtl/rx_delay_normalizer.sv
module rx_delay_normalizer
    import rxn_pkg::*;
#(
    parameter int COARSE_W = 4,
    parameter int DIG_W    = 8,
    parameter int T_FAST   = 9,
    parameter int P_FAST   = 8,
    parameter int T_SLOW   = 12,
    parameter int P_SLOW   = 1,
    parameter int PH_STEP  = 2,
    parameter int PH_BOUND = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fast_grade,
    input  logic                 load,
    input  logic [COARSE_W-1:0]  ld_coarse,
    input  logic [PH_W-1:0]      ld_phase,
    input  logic [TAP_W-1:0]     ld_tap,
    input  logic [FINE_W-1:0]    ld_fine,
    input  logic [PRE_W-1:0]     ld_pre,
    input  logic                 op_valid,
    input  logic [OP_W-1:0]      op,
    output logic [COARSE_W-1:0]  coarse_out,
    output logic [PH_W-1:0]      phase_out,
    output logic [TAP_W-1:0]     tap_out,
    output logic [FINE_W-1:0]    fine_out,
    output logic [WORD_W-1:0]    grp_word,
    output logic [WORD_W-1:0]    chan_word,
    output logic                 done,
    output logic                 err
);

    localparam logic signed [DIG_W-1:0] TB_F  = DIG_W'(T_FAST);
    localparam logic signed [DIG_W-1:0] PB_F  = DIG_W'(P_FAST);
    localparam logic signed [DIG_W-1:0] TB_S  = DIG_W'(T_SLOW);
    localparam logic signed [DIG_W-1:0] PB_S  = DIG_W'(P_SLOW);
    localparam logic signed [DIG_W-1:0] C_MAX = DIG_W'((1 << COARSE_W) - 1);

    rxn_state_e state_q, state_d;

    logic signed [DIG_W-1:0] coarse_q, phase_q, tap_q, fine_q;
    logic [PRE_W-1:0]        pre_q;
    logic                    speed_q;
    logic                    err_q;

    logic signed [DIG_W-1:0] cur_tb, cur_pb, run_tb, run_pb;
    logic signed [DIG_W-1:0] st_coarse, st_phase, st_tap, st_fine;
    logic signed [DIG_W-1:0] cy_coarse, cy_phase, cy_tap, cy_fine;
    logic                    cy_settled;
    logic                    accept;
    logic                    coarse_bad;

    assign cur_tb = fast_grade ? TB_F : TB_S;
    assign cur_pb = fast_grade ? PB_F : PB_S;
    assign run_tb = speed_q ? TB_F : TB_S;
    assign run_pb = speed_q ? PB_F : PB_S;

    assign accept     = (state_q == S_IDLE) && op_valid && !err_q && !load;
    assign coarse_bad = (coarse_q < 0) || (coarse_q > C_MAX);

    rxn_step_apply #(.DIG_W(DIG_W), .PH_STEP(PH_STEP)) u_step (
        .op_i     (rxn_op_e'(op)),
        .tb_i     (cur_tb),
        .pb_i     (cur_pb),
        .coarse_i (coarse_q),
        .phase_i  (phase_q),
        .tap_i    (tap_q),
        .fine_i   (fine_q),
        .coarse_o (st_coarse),
        .phase_o  (st_phase),
        .tap_o    (st_tap),
        .fine_o   (st_fine)
    );

    rxn_carry_unit #(.DIG_W(DIG_W), .PH_STEP(PH_STEP), .PH_BOUND(PH_BOUND)) u_carry (
        .tb_i      (run_tb),
        .pb_i      (run_pb),
        .coarse_i  (coarse_q),
        .phase_i   (phase_q),
        .tap_i     (tap_q),
        .fine_i    (fine_q),
        .coarse_o  (cy_coarse),
        .phase_o   (cy_phase),
        .tap_o     (cy_tap),
        .fine_o    (cy_fine),
        .settled_o (cy_settled)
    );

    rxn_pack #(.COARSE_W(COARSE_W)) u_pack (
        .tap_i       (tap_q[TAP_W-1:0]),
        .fine_i      (fine_q[FINE_W-1:0]),
        .phase_i     (phase_q[PH_W-1:0]),
        .pre_i       (pre_q),
        .coarse_i    (coarse_q[COARSE_W-1:0]),
        .grp_word_o  (grp_word),
        .chan_word_o (chan_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: load, accept, settle, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (load || accept) state_d = S_NORM;
            S_NORM: if (!load && cy_settled) state_d = S_IDLE;
        endcase
    end

    // Digit datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            phase_q  <= '0;
            tap_q    <= '0;
            fine_q   <= '0;
            pre_q    <= '0;
            speed_q  <= 1'b0;
            err_q    <= 1'b0;
        end else if (load) begin
            coarse_q <= {{(DIG_W-COARSE_W){1'b0}}, ld_coarse};
            phase_q  <= {{(DIG_W-PH_W){1'b0}}, ld_phase};
            tap_q    <= {{(DIG_W-TAP_W){1'b0}}, ld_tap};
            fine_q   <= {{(DIG_W-FINE_W){1'b0}}, ld_fine};
            pre_q    <= ld_pre;
            speed_q  <= fast_grade;
            err_q    <= 1'b0;
        end else if (accept) begin
            coarse_q <= st_coarse;
            phase_q  <= st_phase;
            tap_q    <= st_tap;
            fine_q   <= st_fine;
            speed_q  <= fast_grade;
        end else if (state_q == S_NORM) begin
            coarse_q <= cy_coarse;
            phase_q  <= cy_phase;
            tap_q    <= cy_tap;
            fine_q   <= cy_fine;
            if (cy_settled) err_q <= coarse_bad;
        end
    end

    // Outputs
    always_comb begin
        done       = (state_q == S_IDLE) && !err_q;
        err        = err_q;
        coarse_out = coarse_q[COARSE_W-1:0];
        phase_out  = phase_q[PH_W-1:0];
        tap_out    = tap_q[TAP_W-1:0];
        fine_out   = fine_q[FINE_W-1:0];
    end

    // Weighted value in half-phase units of fine steps
    int wsum;
    assign wsum = 2 * int'(fine_q) + 2 * int'(run_pb) * int'(tap_q)
                + int'(run_pb) * int'(run_tb) * int'(phase_q)
                + 4 * int'(run_pb) * int'(run_tb) * int'(coarse_q);

    p_conserve_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_NORM && !load) |=> (wsum == $past(wsum)));

    p_accept_drops_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_valid && !load) |=> !done);

    p_fine_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fine_q >= 0 && fine_q < run_pb));

    p_tap_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tap_q >= 0 && tap_q < run_tb));

    p_phase_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase_q >= 0 && phase_q < DIG_W'(PH_BOUND)));

    p_coarse_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (coarse_q >= 0 && coarse_q <= C_MAX));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !load) |=> err);

    p_err_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !load) |=> ($stable(coarse_q) && $stable(phase_q) && $stable(tap_q) && $stable(fine_q)));

    p_load_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!err && !done));

endmodule

// File: tb/rx_delay_normalizer_bench.sv
module rx_delay_normalizer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fast_grade, load, op_valid;
    logic [3:0]  ld_coarse, ld_tap;
    logic [1:0]  ld_phase, ld_pre;
    logic [2:0]  ld_fine, op;
    logic [3:0]  coarse_out, tap_out;
    logic [1:0]  phase_out;
    logic [2:0]  fine_out;
    logic [31:0] grp_word, chan_word;
    logic        done, err;

    int checks = 0;
    int errors = 0;
    int mc, mph, mt, mf, mpre, merr, msteps, tb, pb;

    always #2 clk = ~clk;

    rx_delay_normalizer u_rx_delay_normalizer (
        .clk(clk), .rst_n(rst_n), .fast_grade(fast_grade), .load(load),
        .ld_coarse(ld_coarse), .ld_phase(ld_phase), .ld_tap(ld_tap),
        .ld_fine(ld_fine), .ld_pre(ld_pre), .op_valid(op_valid), .op(op),
        .coarse_out(coarse_out), .phase_out(phase_out), .tap_out(tap_out),
        .fine_out(fine_out), .grp_word(grp_word), .chan_word(chan_word),
        .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_grade(input int fast);
        tb = fast ? 9 : 12;
        pb = fast ? 8 : 1;
    endtask

    task automatic model_norm();
        msteps = 0;
        while (1) begin
            if (mf >= pb)      begin mf -= pb; mt += 1; end
            else if (mf < 0)   begin mf += pb; mt -= 1; end
            else if (mt >= tb) begin mt -= tb; mph += 2; end
            else if (mt < 0)   begin mt += tb; mph -= 2; end
            else if (mph >= 4) begin mph -= 4; mc += 1; end
            else if (mph < 0)  begin mph += 4; mc -= 1; end
            else break;
            msteps++;
        end
        merr = (mc < 0 || mc > 15) ? 1 : 0;
    endtask

    task automatic model_op(input int o);
        case (o)
            0: begin mt += tb >> 1; mf += (tb & 1) * (pb >> 1); end
            1: begin mt -= tb >> 1; mf -= (tb & 1) * (pb >> 1); end
            2: mc -= 1;
            3: mph -= 2;
            4: mf += 1;
            default: ;
        endcase
    endtask

    task automatic wait_settle(output int cnt);
        cnt = 0;
        while (!(done || err) && cnt < 64) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic check_state(input string tag);
        check(err == merr[0], {tag, " err"}, int'(err), merr);
        if (merr == 0) begin
            check(coarse_out == mc[3:0], {tag, " coarse"}, int'(coarse_out), mc);
            check(phase_out == mph[1:0], {tag, " phase"}, int'(phase_out), mph);
            check(tap_out == mt[3:0], {tag, " tap"}, int'(tap_out), mt);
            check(fine_out == mf[2:0], {tag, " fine"}, int'(fine_out), mf);
        end
    endtask

    task automatic check_words();
        int eg, ec;
        eg = (mt << 28) | (mf << 24) | (mph << 22) | (mpre << 20);
        ec = mc << 7;
        check(grp_word == 32'(eg), "R11 grp_word", int'(grp_word), eg);
        check(chan_word == 32'(ec), "R11 chan_word", int'(chan_word), ec);
    endtask

    task automatic do_load(input int fast, input int c, input int ph, input int t,
                           input int f, input int pre, input bit with_op);
        int cnt;
        @(negedge clk);
        fast_grade = fast[0];
        ld_coarse = c[3:0]; ld_phase = ph[1:0]; ld_tap = t[3:0];
        ld_fine = f[2:0]; ld_pre = pre[1:0];
        load = 1'b1;
        op_valid = with_op; op = 3'd2;
        @(negedge clk);
        load = 1'b0; op_valid = 1'b0;
        set_grade(fast);
        mc = c; mph = ph; mt = t; mf = f; mpre = pre;
        model_norm();
        wait_settle(cnt);
        check(cnt == msteps + 1, "R8 load latency", cnt, msteps + 1);
        check_state("R2 load");
    endtask

    task automatic do_op(input int fast, input int o, output int cnt);
        @(negedge clk);
        fast_grade = fast[0];
        op_valid = 1'b1; op = o[2:0];
        @(negedge clk);
        op_valid = 1'b0;
        set_grade(fast);
        model_op(o);
        model_norm();
        wait_settle(cnt);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        logic [3:0] sc, st;
        logic [1:0] sp;
        logic [2:0] sf;
        rst_n = 1'b0; fast_grade = 1'b0; load = 1'b0; op_valid = 1'b0; op = '0;
        ld_coarse = '0; ld_phase = '0; ld_tap = '0; ld_fine = '0; ld_pre = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(done == 1'b1 && err == 1'b0, "R1 done/err", int'({done, err}), 2);
        check(coarse_out == 0 && phase_out == 0 && tap_out == 0 && fine_out == 0,
              "R1 digits", int'(coarse_out) + int'(tap_out), 0);
        check(grp_word == 0 && chan_word == 0, "R1 words", int'(grp_word), 0);

        // R2: load and op in the same cycle, load wins
        do_load(1, 5, 1, 3, 2, 1, 1'b1);
        check(coarse_out == 4'd5, "R2 collision coarse", int'(coarse_out), 5);

        // R10: command while normalizing is dropped (fast, tap 15 fine 7 needs steps)
        @(negedge clk);
        fast_grade = 1'b1; ld_coarse = 4'd2; ld_phase = 2'd0; ld_tap = 4'd15;
        ld_fine = 3'd7; ld_pre = 2'd0; load = 1'b1;
        @(negedge clk);
        load = 1'b0; op_valid = 1'b1; op = 3'd2;
        @(negedge clk);
        op_valid = 1'b0;
        set_grade(1); mc = 2; mph = 0; mt = 15; mf = 7; mpre = 0;
        model_norm();
        wait_settle(cnt);
        check_state("R10 busy op");

        // R3: grade flipped mid-normalization, sampled grade holds
        @(negedge clk);
        fast_grade = 1'b1; ld_coarse = 4'd3; ld_phase = 2'd1; ld_tap = 4'd15;
        ld_fine = 3'd7; ld_pre = 2'd2; load = 1'b1;
        @(negedge clk);
        load = 1'b0; fast_grade = 1'b0;
        set_grade(1); mc = 3; mph = 1; mt = 15; mf = 7; mpre = 2;
        model_norm();
        wait_settle(cnt);
        check_state("R3 grade latch");
        check_words();

        // R9: borrow below coarse 0 raises err, op then ignored, load clears
        do_load(1, 0, 0, 0, 0, 0, 1'b0);
        do_op(1, 3, cnt);
        check(err == 1'b1 && done == 1'b0, "R9 err raised", int'(err), 1);
        sc = coarse_out; sp = phase_out; st = tap_out; sf = fine_out;
        @(negedge clk);
        op_valid = 1'b1; op = 3'd4;
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(coarse_out == sc && phase_out == sp && tap_out == st && fine_out == sf
              && err == 1'b1 && done == 1'b0, "R9 frozen", int'(fine_out), int'(sf));
        do_load(0, 1, 0, 0, 0, 0, 1'b0);
        check(err == 1'b0 && done == 1'b1, "R9 cleared by load", int'(err), 0);

        // Sweep: R4 R5 R6 R7 R8 R11
        for (int g = 0; g < 2; g++)
            for (int c = 0; c < 16; c += 15)
                for (int ph = 0; ph < 4; ph++)
                    for (int t = 0; t < 16; t++)
                        for (int f = 0; f < 8; f += 7)
                            for (int o = 0; o < 8; o++) begin
                                do_load(g, c, ph, t, f, (t + ph) % 4, 1'b0);
                                if (merr == 0) begin
                                    do_op(g, o, cnt);
                                    check(cnt == msteps + 1, "R8 op latency", cnt, msteps + 1);
                                    check_state("R4 R5 R6 R7 op");
                                    if (merr == 0) check_words();
                                end
                            end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule